// File: doc/BRIEF.md
# Clock Generator Watchdog with Safe-Code Fallback

This block supervises a clock generator. It watches a programmable interval that is counted in ticks of a strobe prescaled from the reference clock. If the host does not kick it within that interval, it raises an alarm flag and replaces the live frequency-select code with a stored safe code. It also drives an active-low system reset pulse so that the system restarts at the fallback frequency.

The same reset pulse fires whenever the host writes a different frequency code, because a change of gear ratio also needs a system restart. The interval is a 3-bit multiplier times a time unit. The unit is either short or four times longer, chosen by one select bit, and both unit lengths are parameters so that simulation can use short ones. The output side is a small state machine with three states. `WS_OFF` is the disabled state. `WS_ARMED` is the state in which the timer counts. `WS_ALARM` is the state after a timeout.

The transitions are as follows:
- OFF→ARMED when the enable is high.
- ARMED→ALARM on expiry while still enabled.
- ARMED→OFF and ALARM→OFF when the enable is low.

Top module: `clkgen_watchdog`

## Requirements
- R1: While reset is held, `alarm` is 0 and `sys_reset_n` is 1. On the first clock after reset is released, `freq_code` takes `host_code` without a reset pulse.
- R2: While `wd_enable` is 0, ticks never cause an alarm or a reset pulse, and `freq_code` is left unchanged.
- R3: With `base_long`=0 and enabled, `alarm` rises after exactly `interval_mult`×SHORT_UNIT_TICKS ticks counted in the armed state, and not before.
- R4: With `base_long`=1, the interval is `interval_mult`×LONG_UNIT_TICKS ticks.
- R5: A multiplier of 0 expires on the first tick after arming.
- R6: On expiry, `freq_code` becomes `safe_code` and `alarm` goes to 1 in the next cycle, unless the host changes its code in that same cycle; in that case the host code wins.
- R7: Expiry drives `sys_reset_n` low in the next cycle. It stays low until PULSE_TICKS further ticks have occurred, then returns to 1.
- R8: A change of `host_code` is copied to `freq_code` in the next cycle and starts the same reset pulse. This also holds in the alarm state, and the alarm stays set.
- R9: A `kick` strobe while armed restarts the full interval.
- R10: A change of `base_long` or `interval_mult` while armed restarts the interval with the new value.
- R11: Clearing `wd_enable` clears `alarm` in the next cycle and stops the count. Re-enabling starts a full new interval.
- R12: In the alarm state, further ticks and kicks cause no new reset pulse and no change of `freq_code`, and `alarm` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe prescaled from the reference clock |
| wd_enable | input | 1 | Watchdog enable |
| base_long | input | 1 | Time unit select: 0 short, 1 long |
| interval_mult | input | 3 | Number of time units per interval |
| safe_code | input | 5 | Fallback frequency code loaded on timeout |
| kick | input | 1 | Service strobe that restarts the interval |
| host_code | input | 5 | Frequency code written by the host |
| freq_code | output | 5 | Active frequency-select code |
| alarm | output | 1 | Timeout status: 1 after expiry |
| sys_reset_n | output | 1 | Active-low system reset pulse |

## Verification
The timeout path is driven through several cases:
- Short and long units with nonzero multipliers, checked one tick before and exactly at the boundary. This separates the correct count from an off-by-one count and from a swapped unit.
- A zero multiplier, which shows that the count does not wrap around.
- A kick and a mid-count change of multiplier. Here the expected alarm tick differs from what a timer without reload would give.

Host code changes are tried both outside and inside the alarm state, to show that the host code overrides the safe code and still restarts the system. Disabled operation and the hold behaviour in the alarm state check that no stray pulses or code changes appear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int MULT_W = 3;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_ARMED = 2'd1,
        WS_ALARM = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
    parameter int SHORT_UNIT_TICKS = 290,
    parameter int LONG_UNIT_TICKS  = 1160,
    parameter int MULT_W           = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              reload,
    input  logic              base_long,
    input  logic [MULT_W-1:0] mult,
    output logic              expire
);

    localparam int MAX_TICKS = ((1 << MULT_W) - 1) * LONG_UNIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] unit_ticks;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    // interval length in ticks: multiplier times selected unit
    always_comb begin
        unit_ticks = base_long ? CNT_W'(LONG_UNIT_TICKS) : CNT_W'(SHORT_UNIT_TICKS);
        load_val   = CNT_W'(mult) * unit_ticks;
    end

    // a remaining count of 0 or 1 ends on the next tick
    assign last_tick = (cnt_q <= CNT_W'(1));
    assign expire    = run && tick && !reload && last_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (run && tick && !last_tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
    parameter int PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trigger,
    output logic reset_n_o
);

    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trigger) begin
            left_q <= PW'(PULSE_TICKS);
        end else if (tick && left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign reset_n_o = (left_q == '0);

endmodule

// File: rtl/wdt_supervisor_fsm.sv
module wdt_supervisor_fsm
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_enable,
    input  logic              expire,
    input  logic [CODE_W-1:0] host_code,
    input  logic [CODE_W-1:0] safe_code,
    output wd_state_e         state_o,
    output logic [CODE_W-1:0] code_o,
    output logic              alarm_o,
    output logic              pulse_trig_o
);

    wd_state_e         state_q;
    wd_state_e         state_d;
    logic              primed_q;
    logic [CODE_W-1:0] host_q;
    logic [CODE_W-1:0] code_q;
    logic              host_change;
    logic              enter_alarm;

    assign host_change = primed_q && (host_code != host_q);
    assign enter_alarm = (state_q == WS_ARMED) && wd_enable && expire;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_OFF:   if (wd_enable) state_d = WS_ARMED;
            WS_ARMED: begin
                if (!wd_enable)  state_d = WS_OFF;
                else if (expire) state_d = WS_ALARM;
            end
            WS_ALARM: if (!wd_enable) state_d = WS_OFF;
            default:  state_d = WS_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_OFF;
        else        state_q <= state_d;
    end

    // registered frequency code: host writes win over the fallback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            host_q   <= '0;
            code_q   <= '0;
        end else begin
            primed_q <= 1'b1;
            host_q   <= host_code;
            if (!primed_q || host_change) code_q <= host_code;
            else if (enter_alarm)         code_q <= safe_code;
        end
    end

    // outputs
    always_comb begin
        state_o      = state_q;
        code_o       = code_q;
        alarm_o      = (state_q == WS_ALARM);
        pulse_trig_o = host_change || enter_alarm;
    end

endmodule

// File: rtl/clkgen_watchdog.sv
module clkgen_watchdog
    import wdt_pkg::*;
#(
    parameter int SHORT_UNIT_TICKS = 290,
    parameter int LONG_UNIT_TICKS  = 1160,
    parameter int PULSE_TICKS      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wd_enable,
    input  logic              base_long,
    input  logic [MULT_W-1:0] interval_mult,
    input  logic [CODE_W-1:0] safe_code,
    input  logic              kick,
    input  logic [CODE_W-1:0] host_code,
    output logic [CODE_W-1:0] freq_code,
    output logic              alarm,
    output logic              sys_reset_n
);

    wd_state_e         state;
    logic              expire;
    logic              pulse_trig;
    logic              base_q;
    logic [MULT_W-1:0] mult_q;
    logic              reprog;
    logic              reload;

    // any rewrite of the interval settings restarts the count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= 1'b0;
            mult_q <= '0;
        end else begin
            base_q <= base_long;
            mult_q <= interval_mult;
        end
    end

    assign reprog = (base_long != base_q) || (interval_mult != mult_q);
    assign reload = kick || reprog || (state != WS_ARMED);

    wdt_interval_timer #(
        .SHORT_UNIT_TICKS (SHORT_UNIT_TICKS),
        .LONG_UNIT_TICKS  (LONG_UNIT_TICKS),
        .MULT_W           (MULT_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (state == WS_ARMED),
        .reload    (reload),
        .base_long (base_long),
        .mult      (interval_mult),
        .expire    (expire)
    );

    wdt_supervisor_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wd_enable    (wd_enable),
        .expire       (expire),
        .host_code    (host_code),
        .safe_code    (safe_code),
        .state_o      (state),
        .code_o       (freq_code),
        .alarm_o      (alarm),
        .pulse_trig_o (pulse_trig)
    );

    wdt_reset_stretch #(
        .PULSE_TICKS (PULSE_TICKS)
    ) stretch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .trigger   (pulse_trig),
        .reset_n_o (sys_reset_n)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wd_enable,
    input logic [4:0] safe_code,
    input logic [4:0] host_code,
    input logic [4:0] freq_code,
    input logic       alarm,
    input logic       sys_reset_n
);

    logic [1:0] ready_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ready_q <= 2'd0;
        else if (ready_q != 2'd2) ready_q <= ready_q + 2'd1;
    end

    // R11
    disable_clears_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wd_enable) |-> !alarm);

    // R8
    host_change_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q != 2'd0 && host_code != $past(host_code))
        |=> (freq_code == $past(host_code) && !sys_reset_n));

    // R6
    safe_code_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alarm) && ready_q == 2'd2 && $past(host_code) == $past(host_code, 2))
        |-> freq_code == $past(safe_code));

    // R7
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> !sys_reset_n);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_reset_n) && ready_q == 2'd2)
        |-> ($rose(alarm) || $past(host_code) != $past(host_code, 2)));

endmodule

bind clkgen_watchdog wdt_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wd_enable   (wd_enable),
    .safe_code   (safe_code),
    .host_code   (host_code),
    .freq_code   (freq_code),
    .alarm       (alarm),
    .sys_reset_n (sys_reset_n)
);

// File: tb/clkgen_watchdog_tb_top.sv
module clkgen_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SHORT_U    = 3;
    localparam int LONG_U     = 12;
    localparam int PULSE_T    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wd_enable = 1'b0;
    logic       base_long = 1'b0;
    logic [2:0] interval_mult = 3'd0;
    logic [4:0] safe_code = 5'h1A;
    logic       kick = 1'b0;
    logic [4:0] host_code = 5'h03;
    logic [4:0] freq_code;
    logic       alarm;
    logic       sys_reset_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkgen_watchdog #(
        .SHORT_UNIT_TICKS (SHORT_U),
        .LONG_UNIT_TICKS  (LONG_U),
        .PULSE_TICKS      (PULSE_T)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .wd_enable     (wd_enable),
        .base_long     (base_long),
        .interval_mult (interval_mult),
        .safe_code     (safe_code),
        .kick          (kick),
        .host_code     (host_code),
        .freq_code     (freq_code),
        .alarm         (alarm),
        .sys_reset_n   (sys_reset_n)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(logic [4:0] host);
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; kick = 1'b0; wd_enable = 1'b0;
        base_long = 1'b0; interval_mult = 3'd0; host_code = host;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic arm(logic lng, logic [2:0] m);
        base_long = lng; interval_mult = m; wd_enable = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; host_code = 5'h07;
        @(negedge clk);
        check("R1 alarm in reset", int'(alarm), 0);
        check("R1 reset_n in reset", int'(sys_reset_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code after release", int'(freq_code), 7);
        check("R1 no pulse after release", int'(sys_reset_n), 1);
    endtask

    task automatic t_disabled();
        apply_reset(5'h04);
        interval_mult = 3'd0;
        ticks(20);
        check("R2 alarm while disabled", int'(alarm), 0);
        check("R2 reset_n while disabled", int'(sys_reset_n), 1);
        check("R2 code while disabled", int'(freq_code), 4);
    endtask

    task automatic t_short();
        apply_reset(5'h03);
        safe_code = 5'h1A;
        arm(1'b0, 3'd2);
        ticks(5);
        check("R3 no alarm before boundary", int'(alarm), 0);
        check("R6 code before boundary", int'(freq_code), 3);
        ticks(1);
        check("R3 alarm at boundary", int'(alarm), 1);
        check("R6 safe code loaded", int'(freq_code), 'h1A);
        check("R7 reset low after expiry", int'(sys_reset_n), 0);
        ticks(1);
        check("R7 reset still low", int'(sys_reset_n), 0);
        ticks(1);
        check("R7 reset released", int'(sys_reset_n), 1);
    endtask

    task automatic t_long();
        apply_reset(5'h03);
        arm(1'b1, 3'd1);
        ticks(11);
        check("R4 no alarm before long boundary", int'(alarm), 0);
        ticks(1);
        check("R4 alarm at long boundary", int'(alarm), 1);
    endtask

    task automatic t_zero();
        apply_reset(5'h03);
        arm(1'b0, 3'd0);
        check("R5 no alarm before tick", int'(alarm), 0);
        ticks(1);
        check("R5 alarm on first tick", int'(alarm), 1);
    endtask

    task automatic t_kick();
        apply_reset(5'h03);
        arm(1'b0, 3'd1);
        ticks(2);
        do_kick();
        ticks(2);
        check("R9 kick restarts interval", int'(alarm), 0);
        ticks(1);
        check("R9 alarm after kicked interval", int'(alarm), 1);
    endtask

    task automatic t_reprog();
        apply_reset(5'h03);
        arm(1'b0, 3'd2);
        ticks(4);
        interval_mult = 3'd1;
        @(negedge clk);
        ticks(2);
        check("R10 reprogram restarts interval", int'(alarm), 0);
        ticks(1);
        check("R10 alarm after new interval", int'(alarm), 1);
    endtask

    task automatic t_host();
        apply_reset(5'h03);
        host_code = 5'h09;
        @(negedge clk);
        check("R8 code follows host", int'(freq_code), 9);
        check("R8 host change pulses reset", int'(sys_reset_n), 0);
        ticks(2);
        check("R8 pulse ends", int'(sys_reset_n), 1);
        check("R8 no alarm from host change", int'(alarm), 0);
    endtask

    task automatic t_alarm_hold();
        apply_reset(5'h03);
        safe_code = 5'h11;
        arm(1'b0, 3'd0);
        ticks(3);
        do_kick();
        ticks(10);
        check("R12 alarm held", int'(alarm), 1);
        check("R12 no new pulse in alarm", int'(sys_reset_n), 1);
        check("R12 safe code held", int'(freq_code), 'h11);
        host_code = 5'h05;
        @(negedge clk);
        check("R8 host overrides safe code", int'(freq_code), 5);
        check("R8 pulse in alarm", int'(sys_reset_n), 0);
        check("R8 alarm kept", int'(alarm), 1);
    endtask

    task automatic t_disable();
        apply_reset(5'h03);
        arm(1'b0, 3'd0);
        ticks(1);
        wd_enable = 1'b0;
        @(negedge clk);
        check("R11 disable clears alarm", int'(alarm), 0);
        ticks(5);
        arm(1'b0, 3'd1);
        ticks(2);
        check("R11 re-enable full interval", int'(alarm), 0);
        ticks(1);
        check("R11 alarm after re-enable", int'(alarm), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled();
        t_short();
        t_long();
        t_zero();
        t_kick();
        t_reprog();
        t_host();
        t_alarm_hold();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule